// File: doc/BRIEF.md
# Programmable Countdown Interval Timer

This block is a down-counting interval timer that raises an interrupt request. A host loads a starting count, picks a clock prescale and sets a control word. The timer then counts elapsed prescaled ticks and emits a single-cycle fire pulse carrying an 8-bit vector each time the count runs out. It can run once (one-shot) or reload itself forever (periodic). A mask bit silences the pulse while counting carries on, so the current count can still be read back.

The prescale is chosen by a sparse 3-bit code spread over bits 3, 1 and 0 of the divide word. It selects division by 2 up to 128, or division by 1. Writing the starting count restarts the whole schedule, including the prescaler phase, from the write cycle. Routing the pulse into an interrupt controller is left to the surrounding logic.

Top module: `cdt_timer`

## Requirements
- R1: After reset the starting count reads 0, the current count reads 0, the control word reads 0x00010000 (masked), the divide word reads 0, and `fire_o` is low.
- R2: The divide word keeps only bits 3, 1 and 0 and reads back with all other bits zero. The code c = {bit3, bit1, bit0} gives shift s = (c + 1) mod 8. One tick occurs every 2^s clocks, so code 0b111 (write value 0xB) ticks on every clock.
- R3: In the control word, bit 17 selects periodic mode (1) or one-shot mode (0), bit 16 masks the pulse, and bits 7:0 hold the vector. A read returns these bits in place and zeros elsewhere.
- R4: Register select codes, used for both writing and reading: 0 is the starting count, 1 is the current count, 2 is the control word, and 3 is the divide word.
- R5: Writing the starting count N at clock edge E loads the count and clears the prescaler. The first tick falls on edge E + 2^s.
- R6: One-shot mode. After t ticks the current count reads N − t, clamped at 0. `fire_o` goes high exactly once, in the cycle that follows edge E + (N+1)·2^s.
- R7: Periodic mode. After t ticks the current count reads N − (t mod (N+1)). `fire_o` goes high after edges E + k·(N+1)·2^s, for k = 1, 2, ….
- R8: In periodic mode with N = 0, no pulse is ever produced.
- R9: While the mask bit is set, no pulse is produced, but counting continues. After the mask is cleared, the next expiry on the original schedule fires. A one-shot expiry that passed while masked is lost.
- R10: Every pulse lasts exactly one cycle, and `fire_vec_o` shows the control vector that was in force at that expiry.
- R11: A write with select code 1 (the current count) is ignored and leaves the count and the schedule unchanged.
- R12: Rewriting the starting count during a run drops the old schedule and restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (R4) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select (R4) |
| rd_data | output | 32 | Combinational read data |
| fire_o | output | 1 | One-cycle expiry pulse |
| fire_vec_o | output | 8 | Vector that goes with the pulse |

## Verification
The bench builds the timer with its default 32-bit count and 8-bit vector. It uses small starting counts (0 to 20) so that one-shot, periodic, masked and restarted runs all complete in a few hundred cycles. It programs divide codes that give shifts of 0, 1, 2, 5 and 7. This covers the wrap to divide-by-one, the default divide-by-two and the widest prescale. Periodic runs use count 4 and count 9 with several expiries, to confirm the N+1 period and the mid-period count values.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int CODE_W   = 3;
  localparam int PRE_W    = (1 << CODE_W) - 1;
  localparam int PER_BIT  = 17;
  localparam int MASK_BIT = 16;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_CUR   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_DIV   = 2'd3
  } cdt_sel_e;
endpackage

// File: rtl/cdt_rst_sync.sv
`timescale 1ns/1ps
module cdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int VW = VEC_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_sel,
  input  logic [DW-1:0]     cur_count,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     start_q,
  output logic              periodic_q,
  output logic              mask_q,
  output logic [VW-1:0]     vec_q,
  output logic [CODE_W-1:0] shift,
  output logic              load
);
  logic [CODE_W-1:0] code_q, code_n;
  logic [DW-1:0]     start_n;
  logic              periodic_n, mask_n;
  logic [VW-1:0]     vec_n;
  logic              wr_start, wr_ctrl, wr_div;
  logic [DW-1:0]     ctrl_word;

  assign wr_start = wr_en && (cdt_sel_e'(wr_sel) == SEL_START);
  assign wr_ctrl  = wr_en && (cdt_sel_e'(wr_sel) == SEL_CTRL);
  assign wr_div   = wr_en && (cdt_sel_e'(wr_sel) == SEL_DIV);
  assign load     = wr_start;

  always_comb begin
    start_n    = start_q;
    periodic_n = periodic_q;
    mask_n     = mask_q;
    vec_n      = vec_q;
    code_n     = code_q;
    if (wr_start) start_n = wr_data;
    if (wr_ctrl) begin
      periodic_n = wr_data[PER_BIT];
      mask_n     = wr_data[MASK_BIT];
      vec_n      = wr_data[VW-1:0];
    end
    if (wr_div) code_n = {wr_data[3], wr_data[1:0]};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      start_q    <= '0;
      periodic_q <= 1'b0;
      mask_q     <= 1'b1;
      vec_q      <= '0;
      code_q     <= '0;
    end else begin
      start_q    <= start_n;
      periodic_q <= periodic_n;
      mask_q     <= mask_n;
      vec_q      <= vec_n;
      code_q     <= code_n;
    end
  end

  assign shift = code_q + CODE_W'(1);

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[PER_BIT]  = periodic_q;
    ctrl_word[MASK_BIT] = mask_q;
    ctrl_word[VW-1:0]   = vec_q;
  end

  always_comb begin
    case (cdt_sel_e'(rd_sel))
      SEL_START: rd_data = start_q;
      SEL_CUR:   rd_data = cur_count;
      SEL_CTRL:  rd_data = ctrl_word;
      default:   rd_data = DW'({code_q[2], 1'b0, code_q[1:0]});
    endcase
  end
endmodule

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
module cdt_prescale
  import cdt_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              clr,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);
  logic [PW-1:0] pcnt_q, pcnt_n;
  logic [PW-1:0] low_mask;

  always_comb begin
    for (int i = 0; i < PW; i++) low_mask[i] = (i < int'(shift));
  end

  assign tick = &(pcnt_q | ~low_mask);

  always_comb begin
    if (clr) pcnt_n = '0;
    else     pcnt_n = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pcnt_q <= '0;
    else         pcnt_q <= pcnt_n;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sn)
    clr |=> (pcnt_q == '0)); // R5
endmodule

// File: rtl/cdt_core.sv
`timescale 1ns/1ps
module cdt_core
  import cdt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  input  logic [DW-1:0] start_q,
  input  logic          periodic_q,
  input  logic          mask_q,
  input  logic [VW-1:0] vec_q,
  output logic [DW-1:0] cur_count,
  output logic          fire_q,
  output logic [VW-1:0] fire_vec_q
);
  logic [DW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          fire_n;
  logic [VW-1:0] fvec_n;
  logic          wrap;
  logic          may_fire;

  assign wrap     = tick && (cnt_q == '0);
  assign may_fire = periodic_q ? (start_q != '0) : !done_q;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    fire_n = 1'b0;
    fvec_n = fire_vec_q;
    if (load) begin
      cnt_n  = load_val;
      done_n = 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt_n  = start_q;
        done_n = 1'b1;
        fire_n = !mask_q && may_fire;
        if (!mask_q && may_fire) fvec_n = vec_q;
      end else begin
        cnt_n = cnt_q - DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q      <= '0;
      done_q     <= 1'b1;
      fire_q     <= 1'b0;
      fire_vec_q <= '0;
    end else begin
      cnt_q      <= cnt_n;
      done_q     <= done_n;
      fire_q     <= fire_n;
      fire_vec_q <= fvec_n;
    end
  end

  assign cur_count = (!periodic_q && done_q) ? '0 : cnt_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_sn)
    load |=> (cnt_q == $past(load_val))); // R12
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_sn)
    fire_q |=> !fire_q); // R10
  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    mask_q |=> !fire_q); // R9
  AST_ZERO_PERIODIC: assert property (@(posedge clk) disable iff (!rst_sn)
    (periodic_q && (start_q == '0) && !load) |=> !fire_q); // R8
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= start_q); // R7
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          fire_o,
  output logic [VW-1:0] fire_vec_o
);
  logic              rst_sn;
  logic [DW-1:0]     start_q, cur_count;
  logic              periodic_q, mask_q, load, tick;
  logic [VW-1:0]     vec_q;
  logic [CODE_W-1:0] shift;

  cdt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  cdt_regs #(.DW(DW), .VW(VW)) u_regs (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .cur_count  (cur_count),
    .rd_data    (rd_data),
    .start_q    (start_q),
    .periodic_q (periodic_q),
    .mask_q     (mask_q),
    .vec_q      (vec_q),
    .shift      (shift),
    .load       (load)
  );

  cdt_prescale #(.PW(PRE_W)) u_pre (
    .clk    (clk),
    .rst_sn (rst_sn),
    .clr    (load),
    .shift  (shift),
    .tick   (tick)
  );

  cdt_core #(.DW(DW), .VW(VW)) u_core (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .load       (load),
    .load_val   (wr_data),
    .tick       (tick),
    .start_q    (start_q),
    .periodic_q (periodic_q),
    .mask_q     (mask_q),
    .vec_q      (vec_q),
    .cur_count  (cur_count),
    .fire_q     (fire_o),
    .fire_vec_q (fire_vec_o)
  );
endmodule

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  localparam logic [1:0] S_START = 2'd0, S_CUR = 2'd1, S_CTRL = 2'd2, S_DIV = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        fire_o;
  logic [7:0]  fire_vec_o;

  int total = 0, bad = 0, fires = 0, cyc = 0;
  bit mon_on = 0;
  int         exp_cyc[$];
  logic [7:0] exp_vec[$];
  string      exp_tag[$];

  cdt_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .fire_o(fire_o),
    .fire_vec_o(fire_vec_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int c);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1 c = cyc;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel; #1 d = rd_data;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_fire(input int c, input logic [7:0] v, input string tag);
    exp_cyc.push_back(c); exp_vec.push_back(v); exp_tag.push_back(tag);
  endtask

  task automatic drain();
    while (exp_cyc.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && fire_o === 1'b1) begin
      fires++;
      if (exp_cyc.size() == 0) begin
        total++; bad++;
        $display("FAIL R9/R12 unexpected fire act_cyc=%0d exp=none", cyc);
      end else begin
        int ec; logic [7:0] ev; string et;
        ec = exp_cyc.pop_front(); ev = exp_vec.pop_front(); et = exp_tag.pop_front();
        chk({et, " fire cycle"}, cyc, ec);
        chk({"R10 vector ", et}, fire_vec_o, ev);
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, c1, f0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; rd_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1 reset state, R4 select codes
    rd(S_START, d); chk("R1 start", d, 32'h0);
    rd(S_CUR, d);   chk("R1 current", d, 32'h0);
    rd(S_CTRL, d);  chk("R1 control", d, 32'h0001_0000);
    rd(S_DIV, d);   chk("R1 divide", d, 32'h0);
    chk("R1 fire low", {31'b0, fire_o}, 32'h0);

    // R3 control fields
    wr(S_CTRL, 32'hFFFF_FFFF, c0);
    rd(S_CTRL, d); chk("R3 control readback", d, 32'h0003_00FF);
    wr(S_CTRL, 32'h0001_0000, c0);

    // R2 divide keeps bits 3,1,0
    wr(S_DIV, 32'hFFFF_FFFF, c0);
    rd(S_DIV, d); chk("R2 divide readback", d, 32'hB);

    // R6 one-shot, shift 0
    wr(S_CTRL, 32'h41, c0);
    wr(S_START, 32'd5, c0);
    rd(S_START, d); chk("R4 start readback", d, 32'd5);
    expect_fire(c0 + 6, 8'h41, "R6");
    wait_to(c0 + 3); rd(S_CUR, d); chk("R6 count mid", d, 32'd2);
    wait_to(c0 + 10); rd(S_CUR, d); chk("R6 count clamp", d, 32'd0);

    // R2/R5 shift 1 (code 0)
    wr(S_DIV, 32'h0, c0);
    wr(S_CTRL, 32'h42, c0);
    wr(S_START, 32'd3, c0);
    expect_fire(c0 + 8, 8'h42, "R2 shift1");
    wait_to(c0 + 20);

    // R2 shift 5 (code 0b100)
    wr(S_DIV, 32'h8, c0);
    wr(S_CTRL, 32'h43, c0);
    wr(S_START, 32'd1, c0);
    expect_fire(c0 + 64, 8'h43, "R2 shift5");
    wait_to(c0 + 80);

    // R2 shift 7 (code 0b110), R5 start zero
    wr(S_DIV, 32'hA, c0);
    wr(S_CTRL, 32'h44, c0);
    wr(S_START, 32'd0, c0);
    expect_fire(c0 + 128, 8'h44, "R5 shift7");
    wait_to(c0 + 140);

    // R7 periodic, shift 2
    wr(S_DIV, 32'h1, c0);
    wr(S_CTRL, 32'h0002_0055, c0);
    wr(S_START, 32'd4, c0);
    for (int k = 1; k <= 3; k++) expect_fire(c0 + 20 * k, 8'h55, "R7");
    wait_to(c0 + 28); rd(S_CUR, d); chk("R7 count after 7 ticks", d, 32'd2);
    wait_to(c0 + 41); rd(S_CUR, d); chk("R7 count after 10 ticks", d, 32'd4);
    drain();
    wr(S_CTRL, 32'h0003_0055, c0);
    wait_to(c0 + 40);

    // R8 periodic zero
    wr(S_DIV, 32'hB, c0);
    wr(S_CTRL, 32'h0002_0066, c0);
    f0 = fires;
    wr(S_START, 32'd0, c0);
    wait_to(c0 + 40);
    chk("R8 no fire", fires, f0);
    rd(S_CUR, d); chk("R8 count zero", d, 32'd0);

    // R9 masked one-shot expiry is lost
    wr(S_CTRL, 32'h0001_0077, c0);
    f0 = fires;
    wr(S_START, 32'd2, c0);
    wait_to(c0 + 6); rd(S_CUR, d); chk("R9 counts while masked", d, 32'd0);
    wr(S_CTRL, 32'h77, c1);
    wait_to(c1 + 20);
    chk("R9 lost expiry", fires, f0);

    // R9 unmask periodic resumes on schedule
    wr(S_CTRL, 32'h0003_0088, c0);
    wr(S_START, 32'd9, c0);
    expect_fire(c0 + 20, 8'h88, "R9 resume");
    wait_to(c0 + 15);
    wr(S_CTRL, 32'h0002_0088, c1);
    drain();
    wr(S_CTRL, 32'h0003_0088, c1);
    wait_to(c0 + 50);

    // R12 restart drops old schedule
    wr(S_CTRL, 32'h99, c0);
    wr(S_START, 32'd10, c0);
    wait_to(c0 + 5);
    wr(S_START, 32'd3, c1);
    expect_fire(c1 + 4, 8'h99, "R12");
    wait_to(c0 + 30);
    chk("R12 queue drained", exp_cyc.size(), 0);

    // R11 write to current-count select ignored
    wr(S_CTRL, 32'hAA, c0);
    wr(S_START, 32'd20, c0);
    expect_fire(c0 + 21, 8'hAA, "R11");
    wait_to(c0 + 2);
    wr(S_CUR, 32'd5, c1);
    wait_to(c0 + 6); rd(S_CUR, d); chk("R11 count unchanged", d, 32'd14);
    wait_to(c0 + 30);

    repeat (10) @(negedge clk);
    chk("R10 all expected fires seen", exp_cyc.size(), 0);
    summary();
    $finish;
  end
endmodule